// File: doc/BRIEF.md
# Load-Band Mode and Switching-Period Scheduler for a Boost PFC Stage

This block decides how a boost power-factor-correction stage should switch. It classifies the averaged load current against three programmable thresholds with hysteresis, and so places the load in one of four bands. From the band and the averaged line voltage it picks one of four modulation modes: continuous conduction, mixed conduction, discontinuous conduction, or pulse-frequency (burst) operation. For each mode it derives a switching-period word, in system clock cycles, for the PWM generator.

A new mode and a new period are adopted only on the period-end strobe from the PWM generator, so a switching cycle is never cut short. In the two middle bands the switching frequency scales with load, between a floor and a ceiling. At the lightest load the stage runs at a fixed burst frequency. A gate output then switches the stage on and off from the sign and size of the output-voltage error. The thresholds, hysteresis, line limit, frequency slope and burst band come in as static configuration words.

Top module: `pfc_mode_sched`

## Requirements
- R1: After reset the mode is CCM (code 0), the period is CLK_HZ/FMAX_HZ and the gate output is 1.
- R2: Mode and period change only at a clock edge where period_end_i is 1; at any other edge they hold their values.
- R3: A load at or above the upper threshold selects CCM (code 0) with period CLK_HZ/FMAX_HZ.
- R4: A load below the lowest threshold selects PFM (code 3) with period CLK_HZ/FBURST_HZ.
- R5: A load between the middle and upper thresholds selects mixed mode (code 1) when line_i is below cfg_line_hi, and DCM (code 2) when line_i is at or above it.
- R6: A load between the lowest and middle thresholds selects DCM (code 2) whatever the line voltage.
- R7: In mixed and DCM mode the target frequency is FMIN_HZ + load_i*cfg_slope Hz, limited to FMAX_HZ. The period is CLK_HZ divided by that frequency, with the quotient truncated.
- R8: Hysteresis. Moving to a higher band needs load_i at or above that band's threshold plus cfg_hyst. Leaving a band downward needs load_i below its threshold. A load between those two values keeps the present band.
- R9: In PFM the gate output goes to 1 one cycle after verr_i rises above +cfg_burst_band. It goes to 0 one cycle after verr_i falls below -cfg_burst_band. Between those limits it holds its value.
- R10: One cycle after the mode is anything other than PFM, the gate output is 1.
- R11: The period output always lies between CLK_HZ/FMAX_HZ and CLK_HZ/FMIN_HZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_end_i | input | 1 | One-cycle strobe at the end of each switching period |
| load_i | input | LOAD_W | Averaged load current, scaled so full scale is rated load |
| line_i | input | LINE_W | Averaged line-voltage magnitude |
| verr_i | input | VERR_W | Output-voltage error (reference minus output), two's complement |
| cfg_thr_pfm | input | LOAD_W | Lowest threshold (PFM/DCM boundary) |
| cfg_thr_dcm | input | LOAD_W | Middle threshold (DCM/mid boundary) |
| cfg_thr_ccm | input | LOAD_W | Upper threshold (mid/CCM boundary) |
| cfg_hyst | input | LOAD_W | Hysteresis added to a threshold when entering a higher band |
| cfg_line_hi | input | LINE_W | Line level at and above which the upper-middle band uses DCM |
| cfg_slope | input | SLOPE_W | Frequency increase in Hz per load LSB in the middle bands |
| cfg_burst_band | input | VERR_W-1 | Half-width of the burst-gate error band |
| mode_o | output | 2 | Mode code: 0 CCM, 1 mixed, 2 DCM, 3 PFM |
| period_o | output | PER_W | Switching period in clock cycles |
| gate_o | output | 1 | Switching allowed when 1 |

## Verification
The bound checker watches the rules that hold cycle by cycle. Mode and period stay frozen without a strobe. The period stays inside its legal range. CCM and PFM each come with their fixed period word. The gate returns high after any mode other than PFM and follows the error band during bursts. The band classification, the hysteresis margins around each threshold, the choice between mixed mode and DCM by line level, and the load-scaled period arithmetic with its clamp depend on history and configuration. The bench scenarios expose these, both in directed threshold walks and in a reference model run under random load, line and error sequences.

// File: rtl/pfc_sched_pkg.sv
package pfc_sched_pkg;

   typedef enum logic [1:0] {
      MODE_CCM   = 2'd0,
      MODE_MIXED = 2'd1,
      MODE_DCM   = 2'd2,
      MODE_PFM   = 2'd3
   } pfc_mode_e;

   localparam int NUM_THR = 3;

endpackage

// File: rtl/pfc_band_sel.sv
module pfc_band_sel #(
   parameter int LOAD_W = 10
) (
   input  logic [1:0]        band_q,
   input  logic [LOAD_W-1:0] load,
   input  logic [LOAD_W-1:0] thr_pfm,
   input  logic [LOAD_W-1:0] thr_dcm,
   input  logic [LOAD_W-1:0] thr_ccm,
   input  logic [LOAD_W-1:0] hyst,
   output logic [1:0]        band_nxt
);
   import pfc_sched_pkg::*;

   localparam int EXT_W = LOAD_W + 1;

   logic [EXT_W-1:0] thr_a [1:NUM_THR];
   logic [NUM_THR:1] pass;

   assign thr_a[1] = {1'b0, thr_pfm};
   assign thr_a[2] = {1'b0, thr_dcm};
   assign thr_a[3] = {1'b0, thr_ccm};

   for (genvar k = 1; k <= NUM_THR; k++) begin : g_thr
      logic [EXT_W-1:0] lim;
      // a band already held needs only the bare threshold, entry needs the margin
      assign lim     = (32'(band_q) >= k) ? thr_a[k] : thr_a[k] + {1'b0, hyst};
      assign pass[k] = {1'b0, load} >= lim;
   end

   always_comb begin
      if (pass[3])      band_nxt = 2'd3;
      else if (pass[2]) band_nxt = 2'd2;
      else if (pass[1]) band_nxt = 2'd1;
      else              band_nxt = 2'd0;
   end

endmodule

// File: rtl/pfc_period_calc.sv
module pfc_period_calc #(
   parameter int CLK_HZ    = 50_000_000,
   parameter int FMAX_HZ   = 70_000,
   parameter int FMIN_HZ   = 20_000,
   parameter int FBURST_HZ = 20_000,
   parameter int LOAD_W    = 10,
   parameter int SLOPE_W   = 16,
   parameter int PER_W     = 12,
   parameter bit PER_ROUND = 1'b0
) (
   input  logic [1:0]         band,
   input  logic [LOAD_W-1:0]  load,
   input  logic [SLOPE_W-1:0] slope,
   output logic [PER_W-1:0]   period
);
   localparam int PER_MIN = CLK_HZ / FMAX_HZ;
   localparam int PER_MAX = CLK_HZ / FMIN_HZ;

   logic [31:0] f_lin;
   logic [31:0] f_tgt;
   logic [31:0] raw;

   assign f_lin = 32'(FMIN_HZ) + 32'(load) * 32'(slope);

   always_comb begin
      case (band)
         2'd3:    f_tgt = 32'(FMAX_HZ);
         2'd0:    f_tgt = 32'(FBURST_HZ);
         default: f_tgt = (f_lin > 32'(FMAX_HZ)) ? 32'(FMAX_HZ) : f_lin;
      endcase
   end

   if (PER_ROUND) begin : g_round
      assign raw = (32'(CLK_HZ) + (f_tgt >> 1)) / f_tgt;
   end else begin : g_trunc
      assign raw = 32'(CLK_HZ) / f_tgt;
   end

   always_comb begin
      if (raw < 32'(PER_MIN))      period = PER_W'(PER_MIN);
      else if (raw > 32'(PER_MAX)) period = PER_W'(PER_MAX);
      else                         period = raw[PER_W-1:0];
   end

endmodule

// File: rtl/pfc_burst_gate.sv
module pfc_burst_gate #(
   parameter int VERR_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_pfm,
   input  logic signed [VERR_W-1:0] verr,
   input  logic [VERR_W-2:0]        band,
   output logic                     gate
);
   logic signed [VERR_W-1:0] up_lim;
   logic signed [VERR_W-1:0] dn_lim;

   assign up_lim = $signed({1'b0, band});
   assign dn_lim = -up_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gate <= 1'b1;
      else if (!in_pfm)        gate <= 1'b1;
      else if (verr > up_lim)  gate <= 1'b1;
      else if (verr < dn_lim)  gate <= 1'b0;
   end

endmodule

// File: rtl/pfc_mode_sched.sv
module pfc_mode_sched #(
   parameter int CLK_HZ    = 50_000_000,
   parameter int FMAX_HZ   = 70_000,
   parameter int FMIN_HZ   = 20_000,
   parameter int FBURST_HZ = 20_000,
   parameter int LOAD_W    = 10,
   parameter int LINE_W    = 12,
   parameter int VERR_W    = 12,
   parameter int SLOPE_W   = 16,
   parameter int PER_W     = $clog2(CLK_HZ / FMIN_HZ + 1),
   parameter bit PER_ROUND = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              period_end_i,
   input  logic [LOAD_W-1:0] load_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic [VERR_W-1:0] verr_i,
   input  logic [LOAD_W-1:0] cfg_thr_pfm,
   input  logic [LOAD_W-1:0] cfg_thr_dcm,
   input  logic [LOAD_W-1:0] cfg_thr_ccm,
   input  logic [LOAD_W-1:0] cfg_hyst,
   input  logic [LINE_W-1:0] cfg_line_hi,
   input  logic [SLOPE_W-1:0] cfg_slope,
   input  logic [VERR_W-2:0] cfg_burst_band,
   output logic [1:0]        mode_o,
   output logic [PER_W-1:0]  period_o,
   output logic              gate_o
);
   import pfc_sched_pkg::*;

   localparam int PER_MIN = CLK_HZ / FMAX_HZ;
   localparam int PER_MAX = CLK_HZ / FMIN_HZ;

   if (FMIN_HZ <= 0 || FMIN_HZ > FMAX_HZ) begin : g_bad_frange
      $error("frequency floor must be positive and not above the ceiling");
   end
   if (FBURST_HZ < FMIN_HZ || FBURST_HZ > FMAX_HZ) begin : g_bad_burst
      $error("burst frequency must lie inside the frequency range");
   end
   if (PER_MIN < 1 || (1 << PER_W) <= PER_MAX) begin : g_bad_perw
      $error("period word cannot hold the longest period");
   end
   if (LOAD_W < 2 || VERR_W < 2) begin : g_bad_w
      $error("load and error words need at least two bits");
   end

   logic [1:0]       band_q;
   logic [1:0]       band_nxt;
   pfc_mode_e        mode_q;
   pfc_mode_e        mode_nxt;
   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] per_nxt;

   pfc_band_sel #(.LOAD_W(LOAD_W)) u_band (
      .band_q   (band_q),
      .load     (load_i),
      .thr_pfm  (cfg_thr_pfm),
      .thr_dcm  (cfg_thr_dcm),
      .thr_ccm  (cfg_thr_ccm),
      .hyst     (cfg_hyst),
      .band_nxt (band_nxt)
   );

   pfc_period_calc #(
      .CLK_HZ    (CLK_HZ),
      .FMAX_HZ   (FMAX_HZ),
      .FMIN_HZ   (FMIN_HZ),
      .FBURST_HZ (FBURST_HZ),
      .LOAD_W    (LOAD_W),
      .SLOPE_W   (SLOPE_W),
      .PER_W     (PER_W),
      .PER_ROUND (PER_ROUND)
   ) u_per (
      .band   (band_nxt),
      .load   (load_i),
      .slope  (cfg_slope),
      .period (per_nxt)
   );

   always_comb begin
      case (band_nxt)
         2'd3:    mode_nxt = MODE_CCM;
         2'd2:    mode_nxt = (line_i >= cfg_line_hi) ? MODE_DCM : MODE_MIXED;
         2'd1:    mode_nxt = MODE_DCM;
         default: mode_nxt = MODE_PFM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         band_q <= 2'd3;
         mode_q <= MODE_CCM;
         per_q  <= PER_W'(PER_MIN);
      end else if (period_end_i) begin
         band_q <= band_nxt;
         mode_q <= mode_nxt;
         per_q  <= per_nxt;
      end
   end

   pfc_burst_gate #(.VERR_W(VERR_W)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_pfm (mode_q == MODE_PFM),
      .verr   ($signed(verr_i)),
      .band   (cfg_burst_band),
      .gate   (gate_o)
   );

   assign mode_o   = mode_q;
   assign period_o = per_q;

endmodule

// File: rtl/pfc_mode_sched_chk.sv
module pfc_mode_sched_chk #(
   parameter int CLK_HZ    = 50_000_000,
   parameter int FMAX_HZ   = 70_000,
   parameter int FMIN_HZ   = 20_000,
   parameter int FBURST_HZ = 20_000,
   parameter int VERR_W    = 12,
   parameter int PER_W     = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              period_end_i,
   input logic [VERR_W-1:0] verr_i,
   input logic [VERR_W-2:0] cfg_burst_band,
   input logic [1:0]        mode_o,
   input logic [PER_W-1:0]  period_o,
   input logic              gate_o
);
   localparam int PER_MIN   = CLK_HZ / FMAX_HZ;
   localparam int PER_MAX   = CLK_HZ / FMIN_HZ;
   localparam int PER_BURST = CLK_HZ / FBURST_HZ;

   logic signed [VERR_W-1:0] lim;
   assign lim = $signed({1'b0, cfg_burst_band});

   // R2
   hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end_i |=> ($stable(mode_o) && $stable(period_o)));

   // R11
   per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(period_o) >= 32'(PER_MIN)) && (32'(period_o) <= 32'(PER_MAX)));

   // R3
   ccm_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0) |-> (32'(period_o) == 32'(PER_MIN)));

   // R4
   pfm_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3) |-> (32'(period_o) == 32'(PER_BURST)));

   // R10
   gate_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd3) |=> gate_o);

   // R9
   burst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == 2'd3) && ($signed(verr_i) > lim)) |=> gate_o);

   // R9
   burst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == 2'd3) && ($signed(verr_i) < -lim)) |=> !gate_o);

endmodule

bind pfc_mode_sched pfc_mode_sched_chk #(
   .CLK_HZ    (CLK_HZ),
   .FMAX_HZ   (FMAX_HZ),
   .FMIN_HZ   (FMIN_HZ),
   .FBURST_HZ (FBURST_HZ),
   .VERR_W    (VERR_W),
   .PER_W     (PER_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .period_end_i   (period_end_i),
   .verr_i         (verr_i),
   .cfg_burst_band (cfg_burst_band),
   .mode_o         (mode_o),
   .period_o       (period_o),
   .gate_o         (gate_o)
);

// File: tb/pfc_mode_sched_bench.sv
module pfc_mode_sched_bench;

   localparam int CLK_HZ = 50_000_000;
   localparam int FMAX   = 70_000;
   localparam int FMIN   = 20_000;
   localparam int FBST   = 20_000;
   localparam int PMIN   = CLK_HZ / FMAX;
   localparam int PMAX   = CLK_HZ / FMIN;
   localparam int T_PFM  = 102;
   localparam int T_DCM  = 400;
   localparam int T_CCM  = 716;
   localparam int HYST   = 8;
   localparam int LHI    = 2000;
   localparam int BB     = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pe = 1'b0;
   logic [9:0]  load = '0;
   logic [11:0] line = '0;
   logic [11:0] verr = '0;
   logic [15:0] slope = 16'd60;
   logic [1:0]  mode_o;
   logic [11:0] period_o;
   logic        gate_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int m_band = 3;
   int m_mode = 0;
   int m_per = PMIN;
   int m_gate = 1;

   always #10 clk = ~clk;

   pfc_mode_sched u_pfc_mode_sched (
      .clk            (clk),
      .rst_n          (rst_n),
      .period_end_i   (pe),
      .load_i         (load),
      .line_i         (line),
      .verr_i         (verr),
      .cfg_thr_pfm    (10'(T_PFM)),
      .cfg_thr_dcm    (10'(T_DCM)),
      .cfg_thr_ccm    (10'(T_CCM)),
      .cfg_hyst       (10'(HYST)),
      .cfg_line_hi    (12'(LHI)),
      .cfg_slope      (slope),
      .cfg_burst_band (11'(BB)),
      .mode_o         (mode_o),
      .period_o       (period_o),
      .gate_o         (gate_o)
   );

   function automatic int thr_of(int k);
      return (k == 1) ? T_PFM : (k == 2) ? T_DCM : T_CCM;
   endfunction

   // R8 reference: held band needs bare threshold, entry needs threshold plus margin
   function automatic int ref_band(int b, int ld);
      int nb = 0;
      for (int k = 1; k <= 3; k++) begin
         int lim = (b >= k) ? thr_of(k) : thr_of(k) + HYST;
         if (ld >= lim) nb = k;
      end
      return nb;
   endfunction

   function automatic int ref_mode(int b, int ln);
      if (b == 3) return 0;
      if (b == 2) return (ln >= LHI) ? 2 : 1;
      if (b == 1) return 2;
      return 3;
   endfunction

   function automatic int ref_per(int b, int ld, int sl);
      int f;
      int p;
      if (b == 3)      f = FMAX;
      else if (b == 0) f = FBST;
      else begin
         f = FMIN + ld * sl;
         if (f > FMAX) f = FMAX;
      end
      p = CLK_HZ / f;
      if (p < PMIN) p = PMIN;
      if (p > PMAX) p = PMAX;
      return p;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic string mode_req(int m);
      case (m)
         0: return "R3";
         1: return "R5";
         2: return "R6";
         default: return "R4";
      endcase
   endfunction

   // drive at negedge, model at posedge, compare at next negedge
   task automatic step(bit p, int ld, int ln, int ve);
      int sv;
      pe   = p;
      load = 10'(ld);
      line = 12'(ln);
      verr = 12'(ve);
      @(posedge clk);
      sv = $signed(verr);
      if (m_mode != 3)   m_gate = 1;
      else if (sv > BB)  m_gate = 1;
      else if (sv < -BB) m_gate = 0;
      if (p) begin
         m_band = ref_band(m_band, ld);
         m_mode = ref_mode(m_band, ln);
         m_per  = ref_per(m_band, ld, int'(slope));
      end
      @(negedge clk);
      chk(int'(mode_o) == m_mode, mode_req(m_mode), int'(mode_o), m_mode);
      chk(int'(period_o) == m_per, (m_mode == 1 || m_mode == 2) ? "R7" : "R11",
          int'(period_o), m_per);
      chk(int'(gate_o) == m_gate, (m_mode == 3) ? "R9" : "R10", int'(gate_o), m_gate);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mode_o == 2'd0, "R1", int'(mode_o), 0);
      chk(int'(period_o) == PMIN, "R1", int'(period_o), PMIN);
      chk(gate_o == 1'b1, "R1", int'(gate_o), 1);

      // R2 light load without strobe: nothing moves
      step(0, 50, 100, 0);
      chk(mode_o == 2'd0, "R2", int'(mode_o), 0);
      chk(int'(period_o) == PMIN, "R2", int'(period_o), PMIN);

      // R3 heavy load
      step(1, 720, 100, 0);
      // R8 sitting on the upper threshold keeps CCM
      step(1, T_CCM, 100, 0);
      chk(mode_o == 2'd0, "R8", int'(mode_o), 0);
      // R5 one below: mixed at low line, period 50e6/62900 = 794
      step(1, T_CCM - 1, 100, 0);
      chk(int'(period_o) == 794, "R7", int'(period_o), 794);
      // R8 inside the margin stays mixed, at the margin returns to CCM
      step(1, T_CCM + HYST - 1, 100, 0);
      chk(mode_o == 2'd1, "R8", int'(mode_o), 1);
      step(1, T_CCM + HYST, 100, 0);
      chk(mode_o == 2'd0, "R8", int'(mode_o), 0);
      // R5 upper-middle band at high line gives DCM
      step(1, 500, LHI, 0);
      chk(mode_o == 2'd2, "R5", int'(mode_o), 2);
      step(1, 500, LHI - 1, 0);
      chk(mode_o == 2'd1, "R5", int'(mode_o), 1);
      // R6 lower-middle band, high line, period 50e6/38000 = 1315
      step(1, 300, 4000, 0);
      chk(int'(period_o) == 1315, "R6", int'(period_o), 1315);
      // R7 frequency ceiling clamp
      slope = 16'd200;
      step(1, 600, 100, 0);
      chk(int'(period_o) == PMIN, "R7", int'(period_o), PMIN);
      slope = 16'd60;
      // R4 lightest load
      step(1, 50, 100, 0);
      chk(int'(period_o) == PMAX, "R4", int'(period_o), PMAX);
      // R9 burst gate walk
      step(0, 50, 100, BB + 1);
      step(0, 50, 100, 0);
      step(0, 50, 100, -BB - 1);
      chk(gate_o == 1'b0, "R9", int'(gate_o), 0);
      step(0, 50, 100, -BB);
      chk(gate_o == 1'b0, "R9", int'(gate_o), 0);
      step(0, 50, 100, BB);
      chk(gate_o == 1'b0, "R9", int'(gate_o), 0);
      // R8 lowest threshold entry margin
      step(1, T_PFM + HYST - 1, 100, -40);
      chk(mode_o == 2'd3, "R8", int'(mode_o), 3);
      step(1, T_PFM + HYST, 100, -40);
      step(0, T_PFM + HYST, 100, -40);
      chk(gate_o == 1'b1, "R10", int'(gate_o), 1);

      // random mix around the thresholds
      for (int i = 0; i < 4000; i++) begin
         int ld;
         int sel = int'($urandom_range(0, 3));
         if (sel == 0) ld = int'($urandom_range(0, 1023));
         else ld = thr_of(sel) + int'($urandom_range(0, 2 * HYST + 2)) - HYST - 1;
         step($urandom_range(0, 3) == 0, ld, int'($urandom_range(0, 4095)),
              int'($urandom_range(0, 80)) - 40);
      end

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule